// File: doc/BRIEF.md
# Block Write Mask Engine

This block sits in the column write path of a two-bank graphics DRAM. It turns column write commands into the per-column, per-byte and per-bit write controls that the storage array needs. It holds two loadable registers. The first is a color register, whose value is written by block writes. The second is a per-bit write mask, which applies to rows that were opened in masked-write mode. A flag for each bank records whether the row now open in that bank was activated with masked write enabled.

A normal write puts the data-bus word into one column of an eight-column group. A block write is not a burst. It fills up to eight adjacent columns in a single cycle with the stored color. The 32 data-bus bits sampled with the command act as a column/byte enable map across the group. The byte masks from the bus gate both kinds of write. The array itself is not part of this block: the block only drives the strobes, byte enables, bit enables, group address and data word. These outputs appear one cycle after the command is sampled.

Top module: `bwm_top`

## Requirements
- R1: While `rst` is high and on the cycle after it, every output is zero. Reset sets the color register to 0, sets the per-bit mask to all ones and clears the masked-write flag of every bank.
- R2: Commands are sampled on `cmd` at each rising clock edge, with this encoding: 0 = idle, 1 = activate, 2 = write, 3 = block write, 4 = register load. Codes 5 to 7 act as idle. The outputs are registered and reflect the command of the previous edge. After any command other than write or block write, every output is zero, and codes 0 and 5 to 7 change no register.
- R3: A register load writes `dq_in` into the color register when `ld_color` = 1, and into the per-bit mask when `ld_color` = 0. A value loaded at one edge is used by a block write at the next edge.
- R4: An activate stores `act_mw` as the masked-write flag of the bank selected by `bank`. The other bank's flag is left unchanged.
- R5: A block write outputs `blk_addr` = `col_addr[7:3]` and ignores `col_addr[2:0]`. Its `wr_data` is the color register.
- R6: For a block write, `byte_en[4*c+b]` = `dq_in[4*c+b]` AND NOT `dqm[b]`, for column offset c in 0..7 and byte b in 0..3. `col_we[c]` is the OR of the four byte enables of column c.
- R7: For a normal write, only column offset o = `col_addr[2:0]` can be enabled. `byte_en[4*o+b]` = NOT `dqm[b]`, `wr_data` = `dq_in`, and `blk_addr` = `col_addr[7:3]`.
- R8: For both write kinds, `bit_we` equals the per-bit mask register when the addressed bank's masked-write flag is set, and is all ones otherwise.
- R9: A write or block write with `dqm` all ones asserts no column strobe and no byte enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 3 | Command code (R2 encoding) |
| bank | input | 1 | Bank addressed by activate, write or block write |
| act_mw | input | 1 | Masked-write enable given with activate |
| ld_color | input | 1 | Register load target: 1 color, 0 per-bit mask |
| col_addr | input | 8 | Column address |
| dq_in | input | 32 | Data bus: write data, load value or block column/byte map |
| dqm | input | 4 | Byte masks, 1 blocks that byte |
| col_we | output | 8 | Column write strobes within the addressed group |
| byte_en | output | 32 | Byte enables, bit 4*c+b for column c byte b |
| wr_data | output | 32 | Data word for the enabled columns |
| bit_we | output | 32 | Per-bit write enables, 1 takes new data |
| blk_addr | output | 5 | Eight-column group address |

## Verification
The bench feeds block writes whose low column bits are nonzero. A design that used those bits would report a wrong group address or shift the enable map. It sends a block write and a normal write, each with all byte masks set, to catch an engine that still fires a strobe. It runs masked and unmasked writes to the two banks one after the other, so a single shared flag or a flag keyed to the wrong bank shows up in `bit_we`. It also loads the color and uses it at the very next edge, sends an undefined command with load-like operands, and resets in the middle of a run, which exposes stale registers, idle codes that wrongly change state, and reset values that were not restored.

// File: rtl/bwm_pkg.sv
package bwm_pkg;

    typedef enum logic [2:0] {
        CMD_IDLE = 3'd0,
        CMD_ACT  = 3'd1,
        CMD_WR   = 3'd2,
        CMD_BLK  = 3'd3,
        CMD_LD   = 3'd4
    } cmd_e;

    typedef struct packed {
        logic is_act;
        logic is_wr;
        logic is_blk;
        logic is_ld;
    } op_t;

    function automatic op_t decode_cmd(input logic [2:0] code);
        op_t op;
        op = '0;
        case (code)
            CMD_ACT: op.is_act = 1'b1;
            CMD_WR:  op.is_wr  = 1'b1;
            CMD_BLK: op.is_blk = 1'b1;
            CMD_LD:  op.is_ld  = 1'b1;
            default: op = '0;
        endcase
        return op;
    endfunction

endpackage

// File: rtl/bwm_spec_regs.sv
module bwm_spec_regs
    import bwm_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BANKS  = 2,
    localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  op_t               op,
    input  logic [BANK_W-1:0] bank,
    input  logic              act_mw,
    input  logic              ld_color,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] color,
    output logic [DATA_W-1:0] bit_mask,
    output logic              mw_cur
);

    logic [BANKS-1:0] mw_flag;

    always_ff @(posedge clk) begin
        if (rst) begin
            color    <= '0;
            bit_mask <= '1;
        end else if (op.is_ld) begin
            if (ld_color) begin
                color <= dq_in;
            end else begin
                bit_mask <= dq_in;
            end
        end
    end

    for (genvar k = 0; k < BANKS; k++) begin : g_bank
        always_ff @(posedge clk) begin
            if (rst) begin
                mw_flag[k] <= 1'b0;
            end else if (op.is_act && (bank == BANK_W'(k))) begin
                mw_flag[k] <= act_mw;
            end
        end
    end

    assign mw_cur = mw_flag[bank];

endmodule

// File: rtl/bwm_lane_mask.sv
module bwm_lane_mask #(
    parameter int COLS  = 8,
    parameter int BYTES = 4,
    localparam int OFF_W  = $clog2(COLS),
    localparam int MASK_W = COLS * BYTES
) (
    input  logic              is_blk,
    input  logic [OFF_W-1:0]  offset,
    input  logic [MASK_W-1:0] blk_map,
    input  logic [BYTES-1:0]  dqm,
    output logic [MASK_W-1:0] byte_en,
    output logic [COLS-1:0]   col_we
);

    for (genvar c = 0; c < COLS; c++) begin : g_col
        logic hit;
        assign hit = (offset == OFF_W'(c));
        for (genvar b = 0; b < BYTES; b++) begin : g_byte
            assign byte_en[c*BYTES+b] = ~dqm[b] &
                (is_blk ? blk_map[c*BYTES+b] : hit);
        end
        assign col_we[c] = |byte_en[c*BYTES +: BYTES];
    end

endmodule

// File: rtl/bwm_out_stage.sv
module bwm_out_stage #(
    parameter int COLS   = 8,
    parameter int BYTES  = 4,
    parameter int DATA_W = 32,
    parameter int BLK_W  = 5,
    localparam int MASK_W = COLS * BYTES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  logic [COLS-1:0]   nxt_we,
    input  logic [MASK_W-1:0] nxt_be,
    input  logic [DATA_W-1:0] nxt_data,
    input  logic [DATA_W-1:0] nxt_bwe,
    input  logic [BLK_W-1:0]  nxt_blk,
    output logic [COLS-1:0]   col_we,
    output logic [MASK_W-1:0] byte_en,
    output logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] bit_we,
    output logic [BLK_W-1:0]  blk_addr
);

    always_ff @(posedge clk) begin
        if (rst || !fire) begin
            col_we   <= '0;
            byte_en  <= '0;
            wr_data  <= '0;
            bit_we   <= '0;
            blk_addr <= '0;
        end else begin
            col_we   <= nxt_we;
            byte_en  <= nxt_be;
            wr_data  <= nxt_data;
            bit_we   <= nxt_bwe;
            blk_addr <= nxt_blk;
        end
    end

endmodule

// File: rtl/bwm_top.sv
module bwm_top
    import bwm_pkg::*;
#(
    parameter int COLS   = 8,
    parameter int BYTES  = 4,
    parameter int BYTE_W = 8,
    parameter int COL_AW = 8,
    parameter int BANKS  = 2,
    localparam int DATA_W = BYTES * BYTE_W,
    localparam int MASK_W = COLS * BYTES,
    localparam int OFF_W  = $clog2(COLS),
    localparam int BLK_W  = COL_AW - OFF_W,
    localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        cmd,
    input  logic [BANK_W-1:0] bank,
    input  logic              act_mw,
    input  logic              ld_color,
    input  logic [COL_AW-1:0] col_addr,
    input  logic [DATA_W-1:0] dq_in,
    input  logic [BYTES-1:0]  dqm,
    output logic [COLS-1:0]   col_we,
    output logic [MASK_W-1:0] byte_en,
    output logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] bit_we,
    output logic [BLK_W-1:0]  blk_addr
);

    op_t               op;
    logic [DATA_W-1:0] color;
    logic [DATA_W-1:0] bit_mask;
    logic              mw_cur;
    logic [MASK_W-1:0] nxt_be;
    logic [COLS-1:0]   nxt_we;
    logic [DATA_W-1:0] nxt_data;
    logic [DATA_W-1:0] nxt_bwe;

    assign op = decode_cmd(cmd);

    bwm_spec_regs #(
        .DATA_W (DATA_W),
        .BANKS  (BANKS)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .bank     (bank),
        .act_mw   (act_mw),
        .ld_color (ld_color),
        .dq_in    (dq_in),
        .color    (color),
        .bit_mask (bit_mask),
        .mw_cur   (mw_cur)
    );

    bwm_lane_mask #(
        .COLS  (COLS),
        .BYTES (BYTES)
    ) u_lanes (
        .is_blk  (op.is_blk),
        .offset  (col_addr[OFF_W-1:0]),
        .blk_map (dq_in[MASK_W-1:0]),
        .dqm     (dqm),
        .byte_en (nxt_be),
        .col_we  (nxt_we)
    );

    always_comb begin
        nxt_data = op.is_blk ? color : dq_in;
        nxt_bwe  = mw_cur ? bit_mask : '1;
    end

    bwm_out_stage #(
        .COLS   (COLS),
        .BYTES  (BYTES),
        .DATA_W (DATA_W),
        .BLK_W  (BLK_W)
    ) u_out (
        .clk      (clk),
        .rst      (rst),
        .fire     (op.is_wr | op.is_blk),
        .nxt_we   (nxt_we),
        .nxt_be   (nxt_be),
        .nxt_data (nxt_data),
        .nxt_bwe  (nxt_bwe),
        .nxt_blk  (col_addr[COL_AW-1:OFF_W]),
        .col_we   (col_we),
        .byte_en  (byte_en),
        .wr_data  (wr_data),
        .bit_we   (bit_we),
        .blk_addr (blk_addr)
    );

endmodule

// File: rtl/bwm_chk.sv
module bwm_chk
    import bwm_pkg::*;
#(
    parameter int COLS   = 8,
    parameter int BYTES  = 4,
    parameter int DATA_W = 32,
    parameter int COL_AW = 8,
    parameter int BANK_W = 1,
    localparam int MASK_W = COLS * BYTES,
    localparam int OFF_W  = $clog2(COLS),
    localparam int BLK_W  = COL_AW - OFF_W
) (
    input logic              clk,
    input logic              rst,
    input logic [2:0]        cmd,
    input logic [BANK_W-1:0] bank,
    input logic              act_mw,
    input logic              ld_color,
    input logic [COL_AW-1:0] col_addr,
    input logic [DATA_W-1:0] dq_in,
    input logic [BYTES-1:0]  dqm,
    input logic [COLS-1:0]   col_we,
    input logic [MASK_W-1:0] byte_en,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] bit_we,
    input logic [BLK_W-1:0]  blk_addr
);

    logic armed;
    logic armed2;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed  <= 1'b0;
            armed2 <= 1'b0;
        end else begin
            armed  <= 1'b1;
            armed2 <= armed;
        end
    end

    // R2
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(cmd) != CMD_WR && $past(cmd) != CMD_BLK) |->
        (col_we == '0 && byte_en == '0 && wr_data == '0 && bit_we == '0 && blk_addr == '0));

    // R7
    wr_data_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(cmd) == CMD_WR) |->
        (wr_data == $past(dq_in) && $onehot0(col_we)));

    // R9
    dqm_block_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && ($past(cmd) == CMD_WR || $past(cmd) == CMD_BLK) && $past(dqm) == '1) |->
        (col_we == '0 && byte_en == '0));

    // R5
    blk_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(cmd) == CMD_BLK) |->
        (blk_addr == $past(col_addr[COL_AW-1:OFF_W])));

    // R3
    color_use_chk: assert property (@(posedge clk) disable iff (rst)
        (armed2 && $past(cmd, 2) == CMD_LD && $past(ld_color, 2) && $past(cmd) == CMD_BLK) |->
        (wr_data == $past(dq_in, 2)));

endmodule

bind bwm_top bwm_chk #(
    .COLS   (COLS),
    .BYTES  (BYTES),
    .DATA_W (DATA_W),
    .COL_AW (COL_AW),
    .BANK_W (BANK_W)
) u_chk (.*);

// File: tb/tb_bwm_top.sv
module tb_bwm_top;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 17;

    typedef struct packed {
        logic [2:0]  cmd;
        logic        bank;
        logic        act_mw;
        logic        ld_color;
        logic [7:0]  col;
        logic [31:0] dq;
        logic [3:0]  dqm;
        logic [7:0]  e_we;
        logic [31:0] e_be;
        logic [31:0] e_data;
        logic [31:0] e_bwe;
        logic [4:0]  e_blk;
    } vec_t;

    localparam vec_t TBL [NVEC] = '{
        '{3'd4, 1'b0, 1'b0, 1'b1, 8'h00, 32'hCAFEF00D, 4'h0, 8'h00, 32'h0, 32'h0, 32'h0, 5'd0},
        '{3'd4, 1'b0, 1'b0, 1'b0, 8'h00, 32'h0F0F00FF, 4'h0, 8'h00, 32'h0, 32'h0, 32'h0, 5'd0},
        '{3'd1, 1'b0, 1'b1, 1'b0, 8'h00, 32'hFFFFFFFF, 4'h0, 8'h00, 32'h0, 32'h0, 32'h0, 5'd0},
        '{3'd1, 1'b1, 1'b0, 1'b0, 8'h00, 32'hFFFFFFFF, 4'h0, 8'h00, 32'h0, 32'h0, 32'h0, 5'd0},
        '{3'd3, 1'b1, 1'b0, 1'b0, 8'h2D, 32'h000F00F1, 4'h0, 8'h13, 32'h000F00F1, 32'hCAFEF00D, 32'hFFFFFFFF, 5'd5},
        '{3'd3, 1'b0, 1'b0, 1'b0, 8'hFF, 32'hFFFFFFFF, 4'h5, 8'hFF, 32'hAAAAAAAA, 32'hCAFEF00D, 32'h0F0F00FF, 5'd31},
        '{3'd2, 1'b0, 1'b0, 1'b0, 8'h0B, 32'h12345678, 4'h2, 8'h08, 32'h0000D000, 32'h12345678, 32'h0F0F00FF, 5'd1},
        '{3'd2, 1'b1, 1'b0, 1'b0, 8'h07, 32'h89ABCDEF, 4'h0, 8'h80, 32'hF0000000, 32'h89ABCDEF, 32'hFFFFFFFF, 5'd0},
        '{3'd2, 1'b1, 1'b0, 1'b0, 8'h00, 32'h89ABCDEF, 4'hF, 8'h00, 32'h0, 32'h89ABCDEF, 32'hFFFFFFFF, 5'd0},
        '{3'd3, 1'b1, 1'b0, 1'b0, 8'h40, 32'hFFFFFFFF, 4'hF, 8'h00, 32'h0, 32'hCAFEF00D, 32'hFFFFFFFF, 5'd8},
        '{3'd0, 1'b0, 1'b1, 1'b1, 8'h55, 32'hDEADBEEF, 4'h0, 8'h00, 32'h0, 32'h0, 32'h0, 5'd0},
        '{3'd1, 1'b0, 1'b0, 1'b0, 8'h00, 32'h00000000, 4'h0, 8'h00, 32'h0, 32'h0, 32'h0, 5'd0},
        '{3'd2, 1'b0, 1'b0, 1'b0, 8'h10, 32'hA5A5A5A5, 4'h0, 8'h01, 32'h0000000F, 32'hA5A5A5A5, 32'hFFFFFFFF, 5'd2},
        '{3'd7, 1'b0, 1'b1, 1'b1, 8'h00, 32'hDEADBEEF, 4'h0, 8'h00, 32'h0, 32'h0, 32'h0, 5'd0},
        '{3'd3, 1'b0, 1'b0, 1'b0, 8'h18, 32'h80000001, 4'h0, 8'h81, 32'h80000001, 32'hCAFEF00D, 32'hFFFFFFFF, 5'd3},
        '{3'd4, 1'b0, 1'b0, 1'b1, 8'h00, 32'h11223344, 4'h0, 8'h00, 32'h0, 32'h0, 32'h0, 5'd0},
        '{3'd3, 1'b1, 1'b0, 1'b0, 8'h01, 32'h00000010, 4'h0, 8'h02, 32'h00000010, 32'h11223344, 32'hFFFFFFFF, 5'd0}
    };

    logic        clk;
    logic        rst;
    logic [2:0]  cmd;
    logic [0:0]  bank;
    logic        act_mw;
    logic        ld_color;
    logic [7:0]  col_addr;
    logic [31:0] dq_in;
    logic [3:0]  dqm;
    logic [7:0]  col_we;
    logic [31:0] byte_en;
    logic [31:0] wr_data;
    logic [31:0] bit_we;
    logic [4:0]  blk_addr;

    int n_checks;
    int n_fail;
    bit done;

    bwm_top dut (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .bank     (bank),
        .act_mw   (act_mw),
        .ld_color (ld_color),
        .col_addr (col_addr),
        .dq_in    (dq_in),
        .dqm      (dqm),
        .col_we   (col_we),
        .byte_en  (byte_en),
        .wr_data  (wr_data),
        .bit_we   (bit_we),
        .blk_addr (blk_addr)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic string vec_tag(input int i);
        case (i)
            0, 1:    return "R3 R2";
            2, 3:    return "R4 R2";
            4:       return "R5 R6 R8";
            5:       return "R6 R8 R3";
            6:       return "R7 R8";
            7:       return "R7 R4";
            8:       return "R9 R7";
            9:       return "R9 R5";
            10, 11:  return "R2";
            12:      return "R4 R7";
            13:      return "R2 undefined code";
            14:      return "R2 R5 R6";
            default: return "R3 R5 R6";
        endcase
    endfunction

    task automatic drive(input logic [2:0] c, input logic bk, input logic mw,
                         input logic lc, input logic [7:0] ca,
                         input logic [31:0] d, input logic [3:0] m);
        @(negedge clk);
        cmd = c; bank = bk; act_mw = mw; ld_color = lc;
        col_addr = ca; dq_in = d; dqm = m;
        @(posedge clk);
        #1;
    endtask

    task automatic expect_out(input string tag, input logic [7:0] we,
                              input logic [31:0] be, input logic [31:0] data,
                              input logic [31:0] bwe, input logic [4:0] blk);
        n_checks++;
        if (col_we !== we || byte_en !== be || wr_data !== data ||
            bit_we !== bwe || blk_addr !== blk) begin
            n_fail++;
            $display("FAIL %s: got we=%h be=%h data=%h bwe=%h blk=%0d exp we=%h be=%h data=%h bwe=%h blk=%0d",
                     tag, col_we, byte_en, wr_data, bit_we, blk_addr,
                     we, be, data, bwe, blk);
        end
    endtask

    initial begin
        n_checks = 0;
        n_fail = 0;
        done = 1'b0;
        rst = 1'b1;
        cmd = 3'd0; bank = 1'b0; act_mw = 1'b0; ld_color = 1'b0;
        col_addr = 8'h00; dq_in = 32'h0; dqm = 4'h0;

        // R1: outputs held at zero during reset, even with a write pending
        drive(3'd3, 1'b0, 1'b0, 1'b0, 8'hFF, 32'hFFFFFFFF, 4'h0);
        expect_out("R1 during reset", 8'h0, 32'h0, 32'h0, 32'h0, 5'd0);
        drive(3'd0, 1'b0, 1'b0, 1'b0, 8'h00, 32'h0, 4'h0);
        @(negedge clk);
        rst = 1'b0;
        drive(3'd0, 1'b0, 1'b0, 1'b0, 8'h00, 32'h0, 4'h0);
        expect_out("R1 after reset", 8'h0, 32'h0, 32'h0, 32'h0, 5'd0);

        for (int i = 0; i < NVEC; i++) begin
            drive(TBL[i].cmd, TBL[i].bank, TBL[i].act_mw, TBL[i].ld_color,
                  TBL[i].col, TBL[i].dq, TBL[i].dqm);
            expect_out($sformatf("vector %0d %s", i, vec_tag(i)),
                       TBL[i].e_we, TBL[i].e_be, TBL[i].e_data,
                       TBL[i].e_bwe, TBL[i].e_blk);
        end

        // R1: reset in mid-run restores color 0 and an all-ones bit mask
        @(negedge clk);
        rst = 1'b1;
        drive(3'd2, 1'b0, 1'b0, 1'b0, 8'h00, 32'hFFFFFFFF, 4'h0);
        expect_out("R1 mid-run reset", 8'h0, 32'h0, 32'h0, 32'h0, 5'd0);
        @(negedge clk);
        rst = 1'b0;
        drive(3'd1, 1'b0, 1'b1, 1'b0, 8'h00, 32'h0, 4'h0);
        expect_out("R4 R2 activate after reset", 8'h0, 32'h0, 32'h0, 32'h0, 5'd0);
        drive(3'd3, 1'b0, 1'b0, 1'b0, 8'h00, 32'h00000001, 4'h0);
        expect_out("R1 R8 reset register values", 8'h01, 32'h00000001, 32'h0, 32'hFFFFFFFF, 5'd0);

        // R8: a newly loaded mask applies to the masked bank only
        drive(3'd4, 1'b0, 1'b0, 1'b0, 8'h00, 32'h0000FFFF, 4'h0);
        expect_out("R3 mask load idle", 8'h0, 32'h0, 32'h0, 32'h0, 5'd0);
        drive(3'd2, 1'b0, 1'b0, 1'b0, 8'h06, 32'h76543210, 4'h8);
        expect_out("R8 R7 masked bank0", 8'h40, 32'h07000000, 32'h76543210, 32'h0000FFFF, 5'd0);
        drive(3'd2, 1'b1, 1'b0, 1'b0, 8'hF9, 32'h76543210, 4'h0);
        expect_out("R8 R4 unmasked bank1", 8'h02, 32'h000000F0, 32'h76543210, 32'hFFFFFFFF, 5'd31);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        for (int k = 0; k < 20000; k++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule